// File: doc/BRIEF.md
# Field-Configurable Two-Level Logic Array

This block evaluates a set of sum-of-products functions whose structure is chosen at run time. A bank of wide AND gates forms product terms from any selection of the true and inverted forms of the inputs. A second programmable array ORs any chosen subset of those terms into each output. A final XOR stage can invert each output. A product term is built once and can feed as many outputs as need it. An output and its complement therefore cost the same number of terms.

The whole connection pattern lives in one serial chain of configuration flops. The chain holds 2·N_IN·N_TERM + N_TERM·N_OUT + 2·N_OUT bits. Bits are shifted in one per clock while the load strobe is high, and the outputs are forced low during that time. When the strobe is low, the outputs are a purely combinational function of the inputs and the stored pattern. The asynchronous active-low reset is released on the clock through a two-stage synchronizer. Reset clears the whole pattern.

Top module: `pla_core`

## Requirements
- R1: While reset is asserted, and after it is released but before any load, every output is 0 for every input value.
- R2: While `load_en_i` is high, each rising clock shifts `cfg_sin_i` into the top of the chain and moves every stored bit down one place. After CFG_W = 2·N_IN·N_TERM + N_TERM·N_OUT + 2·N_OUT shifts, the first bit sent sits at position 0.
- R3: While `load_en_i` is high, every output is 0.
- R4: Chain bit t·2·N_IN + 2·i connects the true form of input i to product term t, and bit t·2·N_IN + 2·i + 1 connects its inverted form. A term is 1 exactly when every literal connected to it is 1, so a term with nothing connected is 1.
- R5: A term that connects both forms of the same input is always 0.
- R6: Chain bit 2·N_IN·N_TERM + o·N_TERM + t adds term t to the sum of output o. A sum with no terms is 0.
- R7: For output o, chain bit 2·N_IN·N_TERM + N_TERM·N_OUT + 2·o passes the sum to the XOR stage, and the bit one above it inverts the result. The output is (pass AND sum) XOR invert.
- R8: While `load_en_i` is low, `cfg_sin_i` has no effect and the stored pattern is held.
- R9: With 3 inputs (A = bit 2, B = bit 1, C = bit 0) and four shared terms, the block can produce F1 = AB' + AC + A'BC' and F2 = (AC + BC)'. F2 is formed by inverting the sum.
- R10: When the load strobe is low, a change on `in_i` reaches `f_o` in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the configuration chain |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| load_en_i | input | 1 | High to shift configuration bits; forces outputs low |
| cfg_sin_i | input | 1 | Serial configuration bit, first bit ends at position 0 |
| in_i | input | N_IN | Logic inputs |
| f_o | output | N_OUT | Function outputs |

## Verification
Configuration bits take effect at the rising edge that samples them. The output result for any input is due within the same cycle, because the array has no register. The bench changes inputs just after a rising edge and samples at the following falling edge. At every falling edge it compares the outputs with a behavioural model that shifts its own copy of the chain on the same edges. Reset release takes two clock cycles through the synchronizer, so the bench waits several cycles before the first load.

// File: rtl/pla_pkg.sv
package pla_pkg;

  function automatic int cfg_bits(input int n_in, input int n_term, input int n_out);
    return 2 * n_in * n_term + n_term * n_out + 2 * n_out;
  endfunction

endpackage

// File: rtl/pla_cfg_chain.sv
module pla_cfg_chain #(
  parameter int W = 36
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_i,
  input  logic         sin_i,
  output logic [W-1:0] cfg_o
);

  logic [W-1:0] cfg_q;
  logic [W-1:0] cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (shift_i) begin
      cfg_d = {sin_i, cfg_q[W-1:1]};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (shift_i) begin
      cfg_q <= cfg_d;
    end
  end

  assign cfg_o = cfg_q;

  // R2: new bit enters at the top
  a_r2_top_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |=> cfg_q[W-1] == $past(sin_i));

  // R2: stored bits move down by one
  a_r2_move_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |=> cfg_q[W-2:0] == $past(cfg_q[W-1:1]));

  // R8: pattern held when not loading
  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i |=> $stable(cfg_q));

endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane #(
  parameter int N_IN   = 3,
  parameter int N_TERM = 4
) (
  input  logic [N_IN-1:0]          in_i,
  input  logic [2*N_IN*N_TERM-1:0] sel_i,
  output logic [N_TERM-1:0]        term_o
);

  localparam int LW = 2 * N_IN;

  logic [LW-1:0] lit;

  for (genvar i = 0; i < N_IN; i++) begin : g_lit
    assign lit[2*i]   = in_i[i];
    assign lit[2*i+1] = ~in_i[i];
  end

  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    assign term_o[t] = &(lit | ~sel_i[t*LW +: LW]);
  end

endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
  parameter int N_TERM = 4,
  parameter int N_OUT  = 2
) (
  input  logic [N_TERM-1:0]       term_i,
  input  logic [N_TERM*N_OUT-1:0] sel_i,
  output logic [N_OUT-1:0]        sum_o
);

  for (genvar o = 0; o < N_OUT; o++) begin : g_sum
    assign sum_o[o] = |(term_i & sel_i[o*N_TERM +: N_TERM]);
  end

endmodule

// File: rtl/pla_core.sv
module pla_core #(
  parameter int N_IN   = 3,
  parameter int N_TERM = 4,
  parameter int N_OUT  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_en_i,
  input  logic             cfg_sin_i,
  input  logic [N_IN-1:0]  in_i,
  output logic [N_OUT-1:0] f_o
);

  localparam int AND_W = 2 * N_IN * N_TERM;
  localparam int OR_W  = N_TERM * N_OUT;
  localparam int POL_W = 2 * N_OUT;
  localparam int CFG_W = pla_pkg::cfg_bits(N_IN, N_TERM, N_OUT);
  localparam int LW    = 2 * N_IN;

  // reset synchronizer: asynchronous assert, clocked release
  logic [1:0] rst_sync_q;
  logic [1:0] rst_sync_d;
  logic       rst_n;

  always_comb rst_sync_d = {rst_sync_q[0], 1'b1};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= rst_sync_d;
    end
  end

  assign rst_n = rst_sync_q[1];

  logic [CFG_W-1:0]  cfg;
  logic [N_TERM-1:0] term;
  logic [N_OUT-1:0]  sum;
  logic [N_OUT-1:0]  pass;
  logic [N_OUT-1:0]  inv;

  pla_cfg_chain #(.W(CFG_W)) u_chain (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .shift_i(load_en_i),
    .sin_i  (cfg_sin_i),
    .cfg_o  (cfg)
  );

  pla_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) u_and (
    .in_i  (in_i),
    .sel_i (cfg[AND_W-1:0]),
    .term_o(term)
  );

  pla_or_plane #(.N_TERM(N_TERM), .N_OUT(N_OUT)) u_or (
    .term_i(term),
    .sel_i (cfg[AND_W +: OR_W]),
    .sum_o (sum)
  );

  for (genvar o = 0; o < N_OUT; o++) begin : g_pol
    assign pass[o] = cfg[AND_W + OR_W + 2*o];
    assign inv[o]  = cfg[AND_W + OR_W + 2*o + 1];
    assign f_o[o]  = ~load_en_i & ((pass[o] & sum[o]) ^ inv[o]);

    // R7: a blocked sum leaves only the invert bit
    a_r7_blocked: assert property (@(posedge clk_i) disable iff (!rst_n)
      (!load_en_i && !pass[o]) |-> f_o[o] == inv[o]);

    // R6: a sum with no terms is 0
    a_r6_empty_sum: assert property (@(posedge clk_i) disable iff (!rst_n)
      (cfg[AND_W + o*N_TERM +: N_TERM] == '0) |-> !sum[o]);
  end

  for (genvar t = 0; t < N_TERM; t++) begin : g_term_chk
    // R4: an unconnected term is 1
    a_r4_empty_term: assert property (@(posedge clk_i) disable iff (!rst_n)
      (cfg[t*LW +: LW] == '0) |-> term[t]);

    for (genvar i = 0; i < N_IN; i++) begin : g_lit_chk
      // R5: both forms of one input kill the term
      a_r5_contra: assert property (@(posedge clk_i) disable iff (!rst_n)
        (cfg[t*LW + 2*i] && cfg[t*LW + 2*i + 1]) |-> !term[t]);
    end
  end

  // R3: quiet outputs while loading
  a_r3_quiet: assert property (@(posedge clk_i) disable iff (!rst_n)
    load_en_i |-> f_o == '0);

  // R1: no output active straight after reset release
  a_r1_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_n) |-> f_o == '0);

  // R2: the pattern bits exactly fill the chain
  initial a_r2_width: assert (CFG_W == AND_W + OR_W + POL_W);

endmodule

// File: tb/pla_core_tb.sv
`timescale 1ns/1ps
module pla_core_tb;

  localparam int N = 3;
  localparam int P = 4;
  localparam int M = 2;
  localparam int W = 2*N*P + P*M + 2*M;

  logic         clk;
  logic         rst_n;
  logic         load_en;
  logic         sin;
  logic [N-1:0] x;
  logic [M-1:0] f;

  int checks = 0;
  int errors = 0;
  bit live   = 0;
  bit done   = 0;

  logic [W-1:0] model_q;

  pla_core #(.N_IN(N), .N_TERM(P), .N_OUT(M)) u_dut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .load_en_i(load_en),
    .cfg_sin_i(sin),
    .in_i     (x),
    .f_o      (f)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // bench copy of the chain, shifted on the same edges
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_q <= '0;
    else if (load_en) model_q <= {sin, model_q[W-1:1]};
  end

  function automatic int i_and(int t, int i, int neg); return t*2*N + 2*i + neg; endfunction
  function automatic int i_or(int o, int t);           return 2*N*P + o*P + t;   endfunction
  function automatic int i_pass(int o);                return 2*N*P + P*M + 2*o; endfunction
  function automatic int i_inv(int o);                 return 2*N*P + P*M + 2*o + 1; endfunction

  function automatic logic [M-1:0] ref_out(logic [W-1:0] c, logic [N-1:0] v, logic ld);
    logic [M-1:0] r;
    r = '0;
    if (!ld) begin
      for (int o = 0; o < M; o++) begin
        logic s;
        s = 1'b0;
        for (int t = 0; t < P; t++) begin
          logic pt;
          pt = 1'b1;
          for (int i = 0; i < N; i++) begin
            if (c[i_and(t, i, 0)] && !v[i]) pt = 1'b0;
            if (c[i_and(t, i, 1)] &&  v[i]) pt = 1'b0;
          end
          if (c[i_or(o, t)] && pt) s = 1'b1;
        end
        r[o] = (c[i_pass(o)] & s) ^ c[i_inv(o)];
      end
    end
    return r;
  endfunction

  task automatic chk(string req, logic [M-1:0] act, logic [M-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b (in=%b)", req, act, exp, x);
    end
  endtask

  // cycle-by-cycle comparison with the model
  always @(negedge clk) begin
    if (live && !done) chk(load_en ? "R3" : "R10", f, ref_out(model_q, x, load_en));
  end

  task automatic load_cfg(logic [W-1:0] c);
    for (int k = 0; k < W; k++) begin
      @(posedge clk); #1;
      load_en = 1'b1;
      sin     = c[k];
    end
    @(posedge clk); #1;
    load_en = 1'b0;
    sin     = 1'b0;
  endtask

  task automatic sweep_const(string req, logic [M-1:0] exp);
    for (int v = 0; v < (1 << N); v++) begin
      @(posedge clk); #1;
      x = v[N-1:0];
      @(negedge clk);
      chk(req, f, exp);
    end
  endtask

  task automatic finish_run;
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [W-1:0] c;
    rst_n   = 1'b0;
    load_en = 1'b0;
    sin     = 1'b0;
    x       = '0;
    repeat (3) @(negedge clk);
    chk("R1", f, '0);            // R1: during reset
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1 live = 1;
    sweep_const("R1", '0);       // R1: cleared pattern

    // R9 worked case: t0=AB' t1=AC t2=A'BC' t3=BC ; A=x[2] B=x[1] C=x[0]
    c = '0;
    c[i_and(0,2,0)] = 1; c[i_and(0,1,1)] = 1;
    c[i_and(1,2,0)] = 1; c[i_and(1,0,0)] = 1;
    c[i_and(2,2,1)] = 1; c[i_and(2,1,0)] = 1; c[i_and(2,0,1)] = 1;
    c[i_and(3,1,0)] = 1; c[i_and(3,0,0)] = 1;
    c[i_or(0,0)] = 1; c[i_or(0,1)] = 1; c[i_or(0,2)] = 1;
    c[i_or(1,1)] = 1; c[i_or(1,3)] = 1;
    c[i_pass(0)] = 1; c[i_pass(1)] = 1; c[i_inv(1)] = 1;
    load_cfg(c);
    for (int v = 0; v < 8; v++) begin
      logic a, b, cc;
      logic [M-1:0] e;
      @(posedge clk); #1;
      x = v[2:0];
      a = x[2]; b = x[1]; cc = x[0];
      e[0] = (a & ~b) | (a & cc) | (~a & b & ~cc);
      e[1] = ~((a & cc) | (b & cc));
      #1;
      chk("R9", f, e);           // R9/R10: mid-cycle, no edge yet
      @(negedge clk);
      chk("R2", f, e);           // R2: layout landed where stated
    end

    // R4 empty term -> 1 ; R5 contradictory term -> 0
    c = '0;
    c[i_and(1,0,0)] = 1; c[i_and(1,0,1)] = 1;
    c[i_or(0,0)] = 1; c[i_pass(0)] = 1;
    c[i_or(1,1)] = 1; c[i_pass(1)] = 1;
    load_cfg(c);
    for (int v = 0; v < 8; v++) begin
      @(posedge clk); #1;
      x = v[2:0];
      @(negedge clk);
      chk("R4", {1'b0, f[0]}, 2'b01);
      chk("R5", {1'b0, f[1]}, 2'b00);
    end

    // R6 no terms -> 0 ; R7 pass blocked, invert set -> 1
    c = '0;
    c[i_pass(0)] = 1;
    c[i_or(1,0)] = 1; c[i_inv(1)] = 1;
    load_cfg(c);
    sweep_const("R6", 2'b10);
    sweep_const("R7", 2'b10);

    // R7 pass and invert together: empty term -> 1, inverted -> 0
    c[i_pass(1)] = 1;
    load_cfg(c);
    sweep_const("R7", 2'b00);

    // R8: toggle the serial input with the strobe low
    for (int k = 0; k < 12; k++) begin
      @(posedge clk); #1;
      sin = k[0];
    end
    sin = 1'b0;
    sweep_const("R8", 2'b00);

    // R3: outputs quiet during a partial load, then full reload
    @(posedge clk); #1;
    c = '0;
    c[i_inv(0)] = 1; c[i_inv(1)] = 1;
    load_en = 1'b1;
    sin     = 1'b1;
    @(negedge clk);
    chk("R3", f, '0);
    @(posedge clk); #1;
    load_en = 1'b0;
    load_cfg(c);
    sweep_const("R7", 2'b11);

    repeat (2) @(posedge clk);
    finish_run();
  end

endmodule